// File: doc/BRIEF.md
# Three-wire control port register file

This block is the write-only configuration port of an audio converter. A host sends 16-bit command words over three wires: a data line, a shift clock and an active-low latch. The block samples all three wires into its own system clock domain. It shifts each word in MSB first while the latch is low. When the latch rises, it writes the received data byte into one of seven mode registers. It then drives the decoded fields of those registers as plain outputs. These fields cover per-channel attenuation, soft mute, oversampling rate, output disable, de-emphasis, serial audio format, filter rolloff, output phase and zero-flag behaviour.

A write commits only when three conditions hold: the top bit of the word is 0, the 7-bit index is between 16 and 22, and exactly 16 shift-clock rising edges arrived while the latch was low. Any other word is dropped and no register changes. After reset, a counter runs for a programmable number of system clocks. Until that initialisation period ends, every field holds its default and all writes are dropped. The port runs independently of any audio data path.

Top module: `ctlport_regfile`

## Requirements
- R1: Out of reset every field holds its default: both attenuation codes 0xFF, format 3'b101, and all other fields 0.
- R2: A word is taken MSB first. Bit 15 is the must-be-zero flag, bits 14:8 the register index and bits 7:0 the data. Index 16 loads the left attenuation code and index 17 loads the right one. Index 21 is accepted but changes no field.
- R3: Index 18 sets mute from data bits 1:0 (bit 0 left, bit 1 right) and the oversampling select from data bit 6.
- R4: Index 19 sets output disable from data bits 1:0 (bit 0 left), de-emphasis enable from bit 4 and de-emphasis rate from bits 6:5 (00 44.1 kHz, 01 48 kHz, 10 32 kHz, 11 reserved). The rate field stores all four codes as written.
- R5: Index 20 sets the audio format from data bits 2:0 and the rolloff select from bit 5 (0 sharp, 1 slow).
- R6: Index 22 sets output phase invert from data bit 0, zero-flag polarity from bit 1 and combined zero-flag select from bit 2.
- R7: Fields change only on the commit that follows a rising edge of the latch. A complete 16-bit word held with the latch still low changes nothing.
- R8: A word with bit 15 set is dropped.
- R9: A word whose index is below 16 or above 22 is dropped.
- R10: A word that received 15 or 17 shift clocks (any count other than 16) is dropped.
- R11: `init_done` rises INIT_CYCLES system clocks after reset release and then stays high. Before that, every field holds its default and all writes are dropped.
- R12: Each falling edge of the latch clears the shift count, so a correct word sent after an aborted one is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_data | input | 1 | Serial command data, asynchronous |
| ctl_sclk | input | 1 | Serial shift clock, data taken on its rising edge |
| ctl_latch_n | input | 1 | Active-low latch, idles high, rising edge commits |
| init_done | output | 1 | Initialisation period over, writes accepted |
| att_left | output | 8 | Left attenuation code |
| att_right | output | 8 | Right attenuation code |
| mute | output | 2 | Soft mute request, bit 0 left, bit 1 right |
| os_hi | output | 1 | Higher oversampling rate selected |
| dac_off | output | 2 | Output disable, bit 0 left, bit 1 right |
| deemph_en | output | 1 | De-emphasis enable |
| deemph_rate | output | 2 | De-emphasis rate code |
| fmt | output | 3 | Serial audio format code |
| slow_roll | output | 1 | Slow filter rolloff selected |
| phase_inv | output | 1 | Output phase inverted |
| zflag_pol | output | 1 | Zero-flag polarity select |
| zflag_comb | output | 1 | Combined zero-flag select |

## Verification
The bench builds the block with INIT_CYCLES set to 200 instead of 1024 and keeps SYNC_STAGES at 2. With that setting, a whole command word fits inside the initialisation window, so the bench can show a write being dropped during initialisation. It can also pin down the exact clock on which `init_done` rises without spending a thousand idle cycles. The shift clock is held for four system clocks per phase, so each edge on the three wires passes through the two-stage synchroniser cleanly.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;

  localparam int unsigned WORD_BITS = 16;
  localparam int unsigned IDX_BITS  = 7;

  localparam logic [IDX_BITS-1:0] IDX_ATT_L  = 7'd16;
  localparam logic [IDX_BITS-1:0] IDX_ATT_R  = 7'd17;
  localparam logic [IDX_BITS-1:0] IDX_MUTE   = 7'd18;
  localparam logic [IDX_BITS-1:0] IDX_DAC    = 7'd19;
  localparam logic [IDX_BITS-1:0] IDX_FMT    = 7'd20;
  localparam logic [IDX_BITS-1:0] IDX_SPARE  = 7'd21;
  localparam logic [IDX_BITS-1:0] IDX_ZFLAG  = 7'd22;

  typedef struct packed {
    logic [7:0] att_l;
    logic [7:0] att_r;
    logic [1:0] mute;
    logic       os_hi;
    logic [1:0] dac_off;
    logic       deemph_en;
    logic [1:0] deemph_rate;
    logic [2:0] fmt;
    logic       slow_roll;
    logic       phase_inv;
    logic       zflag_pol;
    logic       zflag_comb;
  } ctl_fields_t;

  localparam ctl_fields_t FIELDS_DEFAULT = '{
    att_l:       8'hFF,
    att_r:       8'hFF,
    mute:        2'b00,
    os_hi:       1'b0,
    dac_off:     2'b00,
    deemph_en:   1'b0,
    deemph_rate: 2'b00,
    fmt:         3'b101,
    slow_roll:   1'b0,
    phase_inv:   1'b0,
    zflag_pol:   1'b0,
    zflag_comb:  1'b0
  };

endpackage

// File: rtl/ctlp_sync.sv
// Multi-stage synchroniser for a small bundle of asynchronous wires.
module ctlp_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d_async;
      for (int s = 1; s < int'(STAGES); s++) chain[s] <= chain[s-1];
    end
  end

  assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/ctlp_shifter.sv
// Edge detection, serial shift register, shift-clock count and commit pulse.
module ctlp_shifter
  import ctlp_pkg::*;
#(
  parameter int unsigned NBITS = WORD_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_data,
  input  logic             s_sclk,
  input  logic             s_latch_n,
  output logic             cmt_vld,
  output logic [NBITS-1:0] cmt_word
);

  localparam int unsigned CNT_W = $clog2(NBITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NBITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(NBITS + 1);

  logic             sclk_q;
  logic             latch_q;
  logic [NBITS-1:0] shreg;
  logic [CNT_W-1:0] cnt;

  logic sclk_rise, latch_fall, latch_rise;
  assign sclk_rise  = s_sclk & ~sclk_q;
  assign latch_fall = latch_q & ~s_latch_n;
  assign latch_rise = ~latch_q & s_latch_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      latch_q  <= 1'b1;
      shreg    <= '0;
      cnt      <= '0;
      cmt_vld  <= 1'b0;
      cmt_word <= '0;
    end else begin
      sclk_q  <= s_sclk;
      latch_q <= s_latch_n;
      cmt_vld <= 1'b0;
      if (latch_fall) begin
        cnt <= '0;
      end else if (!s_latch_n && sclk_rise) begin
        shreg <= {shreg[NBITS-2:0], s_data};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
      if (latch_rise) begin
        cmt_vld  <= (cnt == CNT_FULL);
        cmt_word <= shreg;
      end
    end
  end

endmodule

// File: rtl/ctlp_regs.sv
// Initialisation timer and mode field storage with index decode.
module ctlp_regs
  import ctlp_pkg::*;
#(
  parameter int unsigned INIT_CYCLES = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmt_vld,
  input  logic [WORD_BITS-1:0] cmt_word,
  output logic                 init_done,
  output ctl_fields_t          fields_q
);

  localparam int unsigned INIT_W = $clog2(INIT_CYCLES + 1);
  localparam logic [INIT_W-1:0] INIT_END = INIT_W'(INIT_CYCLES);

  logic [INIT_W-1:0] init_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  init_cnt <= '0;
    else if (init_cnt != INIT_END) init_cnt <= init_cnt + 1'b1;
  end

  assign init_done = (init_cnt == INIT_END);

  logic [IDX_BITS-1:0] idx;
  logic [7:0]          dat;
  logic                hit;

  assign idx = cmt_word[WORD_BITS-2 -: IDX_BITS];
  assign dat = cmt_word[7:0];
  assign hit = cmt_vld && !cmt_word[WORD_BITS-1] && init_done &&
               (idx >= IDX_ATT_L) && (idx <= IDX_ZFLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= FIELDS_DEFAULT;
    end else if (hit) begin
      case (idx)
        IDX_ATT_L: fields_q.att_l <= dat;
        IDX_ATT_R: fields_q.att_r <= dat;
        IDX_MUTE: begin
          fields_q.mute  <= dat[1:0];
          fields_q.os_hi <= dat[6];
        end
        IDX_DAC: begin
          fields_q.dac_off     <= dat[1:0];
          fields_q.deemph_en   <= dat[4];
          fields_q.deemph_rate <= dat[6:5];
        end
        IDX_FMT: begin
          fields_q.fmt       <= dat[2:0];
          fields_q.slow_roll <= dat[5];
        end
        IDX_ZFLAG: begin
          fields_q.phase_inv  <= dat[0];
          fields_q.zflag_pol  <= dat[1];
          fields_q.zflag_comb <= dat[2];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ctlport_regfile.sv
module ctlport_regfile
  import ctlp_pkg::*;
#(
  parameter int unsigned INIT_CYCLES = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_data,
  input  logic       ctl_sclk,
  input  logic       ctl_latch_n,
  output logic       init_done,
  output logic [7:0] att_left,
  output logic [7:0] att_right,
  output logic [1:0] mute,
  output logic       os_hi,
  output logic [1:0] dac_off,
  output logic       deemph_en,
  output logic [1:0] deemph_rate,
  output logic [2:0] fmt,
  output logic       slow_roll,
  output logic       phase_inv,
  output logic       zflag_pol,
  output logic       zflag_comb
);

  logic [2:0]           pins_sync;
  logic                 cmt_vld;
  logic [WORD_BITS-1:0] cmt_word;
  ctl_fields_t          fields_q;

  // Order {latch, sclk, data}; latch idles high.
  ctlp_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async({ctl_latch_n, ctl_sclk, ctl_data}),
    .d_sync (pins_sync)
  );

  ctlp_shifter #(.NBITS(WORD_BITS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_data   (pins_sync[0]),
    .s_sclk   (pins_sync[1]),
    .s_latch_n(pins_sync[2]),
    .cmt_vld  (cmt_vld),
    .cmt_word (cmt_word)
  );

  ctlp_regs #(.INIT_CYCLES(INIT_CYCLES)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmt_vld  (cmt_vld),
    .cmt_word (cmt_word),
    .init_done(init_done),
    .fields_q (fields_q)
  );

  assign att_left    = fields_q.att_l;
  assign att_right   = fields_q.att_r;
  assign mute        = fields_q.mute;
  assign os_hi       = fields_q.os_hi;
  assign dac_off     = fields_q.dac_off;
  assign deemph_en   = fields_q.deemph_en;
  assign deemph_rate = fields_q.deemph_rate;
  assign fmt         = fields_q.fmt;
  assign slow_roll   = fields_q.slow_roll;
  assign phase_inv   = fields_q.phase_inv;
  assign zflag_pol   = fields_q.zflag_pol;
  assign zflag_comb  = fields_q.zflag_comb;

endmodule

// File: rtl/ctlp_checker.sv
module ctlp_checker
  import ctlp_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmt_vld,
  input logic [WORD_BITS-1:0] cmt_word,
  input logic                 init_done,
  input ctl_fields_t          fields
);

  logic [IDX_BITS-1:0] c_idx;
  assign c_idx = cmt_word[WORD_BITS-2 -: IDX_BITS];

  assert_change_needs_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fields != $past(fields)) |-> $past(cmt_vld));

  assert_commit_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_vld |=> !cmt_vld);

  assert_msb_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_vld && cmt_word[WORD_BITS-1]) |=> (fields == $past(fields)));

  assert_index_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_vld && ((c_idx < IDX_ATT_L) || (c_idx > IDX_ZFLAG))) |=> (fields == $past(fields)));

  assert_init_defaults_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (fields == FIELDS_DEFAULT));

  assert_init_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

endmodule

bind ctlport_regfile ctlp_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmt_vld  (cmt_vld),
  .cmt_word (cmt_word),
  .init_done(init_done),
  .fields   (fields_q)
);

// File: tb/sim_ctlport_regfile.sv
`timescale 1ns/1ps
module sim_ctlport_regfile;

  localparam int INIT = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_data = 1'b0, ctl_sclk = 1'b0, ctl_latch_n = 1'b1;
  logic init_done;
  logic [7:0] att_left, att_right;
  logic [1:0] mute, dac_off, deemph_rate;
  logic os_hi, deemph_en, slow_roll, phase_inv, zflag_pol, zflag_comb;
  logic [2:0] fmt;

  always #2.5 clk = ~clk;

  ctlport_regfile #(.INIT_CYCLES(INIT), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_data(ctl_data), .ctl_sclk(ctl_sclk),
    .ctl_latch_n(ctl_latch_n), .init_done(init_done), .att_left(att_left),
    .att_right(att_right), .mute(mute), .os_hi(os_hi), .dac_off(dac_off),
    .deemph_en(deemph_en), .deemph_rate(deemph_rate), .fmt(fmt),
    .slow_roll(slow_roll), .phase_inv(phase_inv), .zflag_pol(zflag_pol),
    .zflag_comb(zflag_comb)
  );

  int nchk = 0, nerr = 0, cyc = 0;
  bit finished = 0;
  logic [7:0] m [7];

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  function automatic logic [30:0] obs();
    return {att_left, att_right, mute, os_hi, dac_off, deemph_en, deemph_rate,
            fmt, slow_roll, phase_inv, zflag_pol, zflag_comb};
  endfunction

  function automatic logic [30:0] expv();
    return {m[0], m[1], m[2][1:0], m[2][6], m[3][1:0], m[3][4], m[3][6:5],
            m[4][2:0], m[4][5], m[6][0], m[6][1], m[6][2]};
  endfunction

  task automatic model_reset();
    m[0] = 8'hFF; m[1] = 8'hFF; m[2] = 8'h00; m[3] = 8'h00;
    m[4] = 8'h05; m[5] = 8'h00; m[6] = 8'h00;
  endtask

  task automatic model_write(input logic [15:0] w);
    if (!w[15] && w[14:8] >= 7'd16 && w[14:8] <= 7'd22) m[w[14:8] - 7'd16] = w[7:0];
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_obs(input string tag);
    nchk++;
    if (obs() !== expv()) begin
      nerr++;
      $display("FAIL %s: fields got %h expected %h", tag, obs(), expv());
    end
  endtask

  task automatic check_bit(input string tag, input logic got, input logic want);
    nchk++;
    if (got !== want) begin
      nerr++;
      $display("FAIL %s: got %b expected %b", tag, got, want);
    end
  endtask

  task automatic latch_lo();
    ctl_latch_n = 1'b0; tick(4);
  endtask

  task automatic shift_bits(input logic [15:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      ctl_sclk = 1'b0;
      ctl_data = (i < 16) ? w[15 - i] : 1'b0;
      tick(4);
      ctl_sclk = 1'b1;
      tick(4);
    end
    ctl_sclk = 1'b0;
    tick(4);
  endtask

  task automatic latch_hi();
    ctl_latch_n = 1'b1; tick(12);
  endtask

  task automatic send(input logic [15:0] w, input int n);
    latch_lo(); shift_bits(w, n); latch_hi();
  endtask

  function automatic string tag_of(input logic [15:0] w);
    case (w[14:8])
      7'd18: return "R3";
      7'd19: return "R4";
      7'd20: return "R5";
      7'd22: return "R6";
      default: return "R2";
    endcase
  endfunction

  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    16'h10A5, 16'h1133, 16'h1241, 16'h1202, 16'h1373, 16'h1340,
    16'h1422, 16'h1404, 16'h1605, 16'h1602, 16'h15FF, 16'h137F
  };

  initial begin
    model_reset();
    tick(5);
    rst_n = 1'b1;
    tick(1);
    check_obs("R1 defaults");
    check_bit("R11 init_done low after reset", init_done, 1'b0);

    // R11: write sent during initialisation is dropped
    send(16'h1000, 16);
    check_obs("R11 write during init dropped");
    while (cyc < INIT - 1) tick(1);
    check_bit("R11 init_done before period", init_done, 1'b0);
    while (cyc < INIT + 1) tick(1);
    check_bit("R11 init_done after period", init_done, 1'b1);

    // Table walk: R2..R6
    for (int k = 0; k < NV; k++) begin
      send(VEC[k], 16);
      model_write(VEC[k]);
      check_obs(tag_of(VEC[k]));
    end

    // R7: full word held with latch low does nothing until latch rises
    latch_lo();
    shift_bits(16'h1077, 16);
    tick(12);
    check_obs("R7 no commit while latch low");
    latch_hi();
    model_write(16'h1077);
    check_obs("R7 commit on latch rise");

    // R8: MSB set
    send(16'h9011, 16);
    check_obs("R8 msb set dropped");

    // R9: index out of range
    send(16'h0F12, 16);
    check_obs("R9 index 15 dropped");
    send(16'h1712, 16);
    check_obs("R9 index 23 dropped");

    // R10: wrong shift count
    send(16'h1022, 15);
    check_obs("R10 15 clocks dropped");
    send(16'h1022, 17);
    check_obs("R10 17 clocks dropped");

    // R12: aborted word then full word
    latch_lo();
    shift_bits(16'hFFFF, 10);
    latch_hi();
    check_obs("R12 aborted word dropped");
    send(16'h1144, 16);
    model_write(16'h1144);
    check_obs("R12 word after abort written");

    // R1: reset mid-run restores defaults
    rst_n = 1'b0;
    tick(2);
    model_reset();
    check_obs("R1 defaults after second reset");
    rst_n = 1'b1;
    tick(1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule